// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor over many clock cycles. It delivers a quotient and a remainder, and handles operands either as unsigned integers or as two's-complement signed integers. One radix-2 restoring step runs per clock. Each step shifts a joint remainder/quotient register pair left by one bit and tries to subtract the divisor. A single subtractor serves every step.

Signed division is done on magnitudes. Negative operands are turned positive when the operation is accepted, and the unsigned loop runs on those magnitudes. One further cycle then applies the signs. The quotient truncates toward zero, and the remainder carries the sign of the dividend. A client pulses `start` with the operands present and waits for the one-cycle `done` pulse. It then reads `quotient` and `remainder`, which hold their values until the next operation completes. A zero divisor is not an error: it completes in the usual time with a defined result.

Top module: `seq_restoring_divider`

## Requirements
- R1: After reset, `done` is 0 and both `quotient` and `remainder` are 0.
- R2: With `signed_mode`=0, the block returns `quotient` = floor(dividend/divisor) and `remainder` = dividend mod divisor for any non-zero divisor over the full 32-bit range, including divisors with bit 31 set, where the trial subtraction needs 33 bits.
- R3: With `signed_mode`=1, both operands are read as two's complement. The quotient is truncated toward zero and is negative exactly when the operand signs differ.
- R4: With `signed_mode`=1, a non-zero remainder has the sign of the dividend, and dividend = quotient × divisor + remainder holds modulo 2^32 (for example -17/3 gives -5 rem -2, and -17/-3 gives 5 rem -2).
- R5: `start` is accepted on a rising edge at which the block is idle. `done` is 1 for exactly one cycle, and it rises DW+2 rising edges after the accepting edge (34 for DW=32). The results are valid in that same cycle.
- R6: A `start` that arrives while an operation is in progress is ignored. The running operation finishes on time with its own results.
- R7: A zero divisor completes in the normal time, and `remainder` equals the dividend. In unsigned mode, and in signed mode with a non-negative dividend, `quotient` is all ones. In signed mode with a negative dividend, `quotient` is 1.
- R8: `quotient` and `remainder` change only in the cycle where `done` is 1, and otherwise hold their last values.
- R9: With `signed_mode`=0, bit 31 is a magnitude bit: 0xFFFFFFF9/2 gives 0x7FFFFFFC rem 1, whereas in signed mode the same operands give 0xFFFFFFFD rem 0xFFFFFFFF.
- R10: In signed mode, 0x80000000 / 0xFFFFFFFF wraps to quotient 0x80000000 with remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division with the present operands (taken only when idle) |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| dividend | input | DW | Dividend operand |
| divisor | input | DW | Divisor operand |
| done | output | 1 | One-cycle pulse when results are valid |
| quotient | output | DW | Quotient result |
| remainder | output | DW | Remainder result |

## Verification
Both results become due DW+2 rising edges after the edge that accepts `start`: one load edge, DW iteration edges and one sign edge, so 34 edges for the default width. The bench drives and samples on falling edges and counts edges from the accepting edge until `done` is seen. It requires that count to be exactly 34, compares `quotient` and `remainder` in that very cycle, and expects `done` to be low one cycle later. For the hold and busy-start cases, it samples again several cycles after `done` and after the extra `start` pulse, so that a late or spurious update would show at the ports.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic neg_quo;
        logic neg_rem;
    } sign_fix_t;

endpackage

// File: rtl/sdiv_operand_prep.sv
module sdiv_operand_prep
    import sdiv_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          signed_mode,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] mag_a,
    output logic [DW-1:0] mag_b,
    output sign_fix_t     fix
);
    logic neg_a;
    logic neg_b;

    always_comb begin
        neg_a       = signed_mode & op_a[DW-1];
        neg_b       = signed_mode & op_b[DW-1];
        mag_a       = neg_a ? (~op_a + 1'b1) : op_a;
        mag_b       = neg_b ? (~op_b + 1'b1) : op_b;
        fix.neg_quo = neg_a ^ neg_b;
        fix.neg_rem = neg_a;
    end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] rem_in,
    input  logic [DW-1:0] quo_in,
    input  logic [DW-1:0] dvs,
    output logic [DW-1:0] rem_out,
    output logic [DW-1:0] quo_out
);
    logic [DW:0] shifted;
    logic [DW:0] trial;
    logic        below;

    // shifted < 2*dvs always, so trial lies in (-2^DW, 2^DW) and its
    // top bit is an exact sign.
    always_comb begin
        shifted = {rem_in, quo_in[DW-1]};
        trial   = shifted - {1'b0, dvs};
        below   = trial[DW];
        rem_out = below ? shifted[DW-1:0] : trial[DW-1:0];
        quo_out = {quo_in[DW-2:0], ~below};
    end
endmodule

// File: rtl/sdiv_sign_fix.sv
module sdiv_sign_fix
    import sdiv_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] quo_mag,
    input  logic [DW-1:0] rem_mag,
    input  sign_fix_t     fix,
    output logic [DW-1:0] quo_res,
    output logic [DW-1:0] rem_res
);
    always_comb begin
        quo_res = fix.neg_quo ? (~quo_mag + 1'b1) : quo_mag;
        rem_res = fix.neg_rem ? (~rem_mag + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/seq_restoring_divider.sv
module seq_restoring_divider
    import sdiv_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          signed_mode,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quotient,
    output logic [DW-1:0] remainder
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(DW - 1);

    div_state_e    state;
    logic [CW-1:0] step_cnt;
    logic [DW-1:0] rem_q;
    logic [DW-1:0] quo_q;
    logic [DW-1:0] dvs_q;
    sign_fix_t     fix_q;

    logic [DW-1:0] mag_a;
    logic [DW-1:0] mag_b;
    sign_fix_t     fix_in;
    logic [DW-1:0] rem_nx;
    logic [DW-1:0] quo_nx;
    logic [DW-1:0] quo_fixed;
    logic [DW-1:0] rem_fixed;

    sdiv_operand_prep #(.DW(DW)) u_prep (
        .signed_mode (signed_mode),
        .op_a        (dividend),
        .op_b        (divisor),
        .mag_a       (mag_a),
        .mag_b       (mag_b),
        .fix         (fix_in)
    );

    sdiv_step #(.DW(DW)) u_step (
        .rem_in  (rem_q),
        .quo_in  (quo_q),
        .dvs     (dvs_q),
        .rem_out (rem_nx),
        .quo_out (quo_nx)
    );

    sdiv_sign_fix #(.DW(DW)) u_fix (
        .quo_mag (quo_q),
        .rem_mag (rem_q),
        .fix     (fix_q),
        .quo_res (quo_fixed),
        .rem_res (rem_fixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            step_cnt  <= '0;
            rem_q     <= '0;
            quo_q     <= '0;
            dvs_q     <= '0;
            fix_q     <= '0;
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        rem_q    <= '0;
                        quo_q    <= mag_a;
                        dvs_q    <= mag_b;
                        fix_q    <= fix_in;
                        step_cnt <= '0;
                        state    <= ST_LOOP;
                    end
                end
                ST_LOOP: begin
                    rem_q    <= rem_nx;
                    quo_q    <= quo_nx;
                    step_cnt <= step_cnt + 1'b1;
                    if (step_cnt == LAST_STEP) begin
                        state <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    quotient  <= quo_fixed;
                    remainder <= rem_fixed;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker
    import sdiv_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          signed_mode,
    input logic [DW-1:0] dividend,
    input logic [DW-1:0] divisor,
    input div_state_e    state,
    input logic          done,
    input logic [DW-1:0] quotient,
    input logic [DW-1:0] remainder
);
    localparam int KW = $clog2(DW + 3) + 1;
    localparam logic [KW-1:0] DUE = KW'(DW + 2);

    logic          accepted;
    logic [KW-1:0] since;
    logic [DW-1:0] lat_a;
    logic [DW-1:0] lat_b;
    logic          lat_sm;
    logic [DW-1:0] rebuilt;

    assign accepted = start && (state == ST_IDLE);
    assign rebuilt  = quotient * lat_b + remainder;

    always_ff @(posedge clk) begin
        if (rst) begin
            since  <= '0;
            lat_a  <= '0;
            lat_b  <= '0;
            lat_sm <= 1'b0;
        end else if (accepted) begin
            since  <= KW'(1);
            lat_a  <= dividend;
            lat_b  <= divisor;
            lat_sm <= signed_mode;
        end else if (done) begin
            since <= '0;
        end else if (since != '0) begin
            since <= since + 1'b1;
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_latency_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (since == DUE));

    assert_results_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder)));

    assert_identity_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (rebuilt == lat_a));

    assert_rem_sign_R4: assert property (@(posedge clk) disable iff (rst)
        (done && lat_sm && (remainder != '0)) |-> (remainder[DW-1] == lat_a[DW-1]));

    assert_rem_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !lat_sm && (lat_b != '0)) |-> (remainder < lat_b));

    assert_zero_divisor_R7: assert property (@(posedge clk) disable iff (rst)
        (done && (lat_b == '0)) |-> (remainder == lat_a));
endmodule

bind seq_restoring_divider sdiv_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .signed_mode (signed_mode),
    .dividend    (dividend),
    .divisor     (divisor),
    .state       (state),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder)
);

// File: tb/tb_seq_restoring_divider.sv
module tb_seq_restoring_divider;
    localparam int DW  = 32;
    localparam int DUE = DW + 2;
    localparam int NV  = 18;

    typedef struct packed {
        logic          sm;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] q;
        logic [DW-1:0] r;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'd217,        32'd19,         32'd11,         32'd8},
        '{1'b1, 32'd17,         32'd3,          32'd5,          32'd2},
        '{1'b1, 32'd17,         32'hFFFFFFFD,   32'hFFFFFFFB,   32'd2},
        '{1'b1, 32'hFFFFFFEF,   32'd3,          32'hFFFFFFFB,   32'hFFFFFFFE},
        '{1'b1, 32'hFFFFFFEF,   32'hFFFFFFFD,   32'd5,          32'hFFFFFFFE},
        '{1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0},
        '{1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'd1,          32'd0},
        '{1'b0, 32'd5,          32'd7,          32'd0,          32'd5},
        '{1'b0, 32'h80000000,   32'd3,          32'h2AAAAAAA,   32'd2},
        '{1'b0, 32'hFFFFFFFF,   32'h80000001,   32'd1,          32'h7FFFFFFE},
        '{1'b0, 32'hFFFFFFFF,   32'hFFFFFFFE,   32'd1,          32'd1},
        '{1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000,   32'd0},
        '{1'b0, 32'hFFFFFFF9,   32'd2,          32'h7FFFFFFC,   32'd1},
        '{1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD,   32'hFFFFFFFF},
        '{1'b0, 32'h000004D2,   32'd0,          32'hFFFFFFFF,   32'h000004D2},
        '{1'b1, 32'hFFFFFFFB,   32'd0,          32'd1,          32'hFFFFFFFB},
        '{1'b1, 32'd5,          32'd0,          32'hFFFFFFFF,   32'd5},
        '{1'b1, 32'h80000000,   32'd7,          32'hEDB6DB6E,   32'hFFFFFFFE}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          signed_mode;
    logic [DW-1:0] dividend;
    logic [DW-1:0] divisor;
    logic          done;
    logic [DW-1:0] quotient;
    logic [DW-1:0] remainder;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    seq_restoring_divider #(.DW(DW)) dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .done        (done),
        .quotient    (quotient),
        .remainder   (remainder)
    );

    function automatic string tag_of(int i);
        case (i)
            1, 2, 17:  return "R3";
            3, 4:      return "R4";
            11:        return "R10";
            12, 13:    return "R9";
            14, 15, 16: return "R7";
            default:   return "R2";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic run_div(input logic sm, input logic [DW-1:0] a,
                           input logic [DW-1:0] b, output int edges);
        @(negedge clk);
        signed_mode = sm;
        dividend    = a;
        divisor     = b;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        while (!done && edges < 200) begin
            @(negedge clk);
            edges++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int edges;
        rst         = 1'b1;
        start       = 1'b0;
        signed_mode = 1'b0;
        dividend    = '0;
        divisor     = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "done after reset", DW'(done), '0);
        check("R1", "quotient after reset", quotient, '0);
        check("R1", "remainder after reset", remainder, '0);

        for (int i = 0; i < NV; i++) begin
            run_div(VEC[i].sm, VEC[i].a, VEC[i].b, edges);
            check(tag_of(i), $sformatf("quotient vec %0d", i), quotient, VEC[i].q);
            check(tag_of(i), $sformatf("remainder vec %0d", i), remainder, VEC[i].r);
            // R5: latency and single-cycle pulse
            check("R5", $sformatf("edges to done vec %0d", i), DW'(edges), DW'(DUE));
            @(negedge clk);
            check("R5", $sformatf("done pulse width vec %0d", i), DW'(done), '0);
        end

        // R8: results hold while inputs wander and no start is given
        signed_mode = 1'b1;
        dividend    = 32'h12345678;
        divisor     = 32'd3;
        repeat (6) @(negedge clk);
        check("R8", "quotient held", quotient, VEC[NV-1].q);
        check("R8", "remainder held", remainder, VEC[NV-1].r);

        // R6: start during a running operation is ignored
        signed_mode = 1'b0;
        dividend    = 32'd100;
        divisor     = 32'd7;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        repeat (10) begin
            @(negedge clk);
            edges++;
        end
        dividend = 32'd999;
        divisor  = 32'd1;
        start    = 1'b1;
        @(negedge clk);
        edges++;
        start = 1'b0;
        while (!done && edges < 200) begin
            @(negedge clk);
            edges++;
        end
        check("R6", "quotient with busy start", quotient, 32'd14);
        check("R6", "remainder with busy start", remainder, 32'd2);
        check("R6", "edges with busy start", DW'(edges), DW'(DUE));
        repeat (40) @(negedge clk);
        check("R6", "no second completion quotient", quotient, 32'd14);
        check("R6", "no second completion remainder", remainder, 32'd2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule